// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block decides, every clock cycle, whether a hart must take an interrupt and which line wins. Each line is a candidate when it is both pending and enabled. A per-line delegation mask then sends the candidate to one of two handlers:
- a clear delegation bit marks the line as machine-targeted;
- a set delegation bit marks it as supervisor-targeted.

Each of the two groups is opened or closed by its own rule. That rule depends on the current privilege level and on the global enable bit for that target. The lines that survive from both groups are merged, and the lowest-numbered survivor is chosen.

The choice is registered. One clock edge after the inputs are presented, a valid strobe and the winning line index appear together. When nothing survives, the index reads zero. Trap entry, CSR updates and the sources of the pending bits all sit outside this block.

Top module: `irq_route_sel`

## Requirements
- R1: While synchronous active-high reset is asserted, and on the first edge after it, the valid output is 0 and the index output is 0.
- R2: A line is a candidate only if its pending bit and its enable bit are both 1. A pending line whose enable bit is 0 is never selected.
- R3: A candidate whose delegation bit is 0 is machine-targeted. It is allowed when the privilege input is numerically below 3 (user = 0, supervisor = 1, encoding 2 also counts as below). In machine mode (3) it is allowed only when the machine global enable is 1.
- R4: A candidate whose delegation bit is 1 is supervisor-targeted. It is allowed when the privilege is user (0), or when the privilege is supervisor (1) and the supervisor global enable is 1. It is never allowed at privilege 2 or 3.
- R5: The final set is the union of the allowed machine-targeted and the allowed supervisor-targeted candidates. When that set is non-empty, the lowest-numbered set bit is reported, whichever group it came from.
- R6: When the final set is empty, the valid output is 0 and the index output is 0.
- R7: The valid and index outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R8: The supervisor global enable has no effect on machine-targeted lines. The machine global enable has no effect on supervisor-targeted lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_LINES | Pending interrupt lines |
| en_i | input | NUM_LINES | Per-line enables |
| deleg_i | input | NUM_LINES | Delegation mask, 1 = supervisor-targeted |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| irq_valid_o | output | 1 | Registered take-interrupt flag |
| irq_idx_o | output | $clog2(NUM_LINES) | Registered index of the selected line |

## Verification
The machine-targeted gate and the supervisor-targeted gate can both pass candidates in the same cycle. In that cycle the priority pick has to choose across the two groups. The bench provokes this by asserting all sixteen lines with the low half delegated. It then steps the privilege level and the two global enables so that either group, or both, may open. The reported index is judged each time against the lowest line of whichever groups are open: 8 when only the machine half may fire, 0 once the supervisor half opens.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Machine-targeted lines may fire below machine level, or in machine
  // level with the machine global enable set.
  function automatic logic mach_lines_open(input priv_e priv, input logic mie);
    return (priv < PRIV_MACH) || ((priv == PRIV_MACH) && mie);
  endfunction

  // Supervisor-targeted lines may fire below supervisor level, or in
  // supervisor level with the supervisor global enable set.
  function automatic logic super_lines_open(input priv_e priv, input logic sie);
    return (priv < PRIV_SUPER) || ((priv == PRIV_SUPER) && sie);
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic [NUM_LINES-1:0] deleg_i,
  input  priv_e                priv_i,
  input  logic                 mie_i,
  input  logic                 sie_i,
  output logic                 m_ok_o,
  output logic                 s_ok_o,
  output logic [NUM_LINES-1:0] final_o
);

  logic [NUM_LINES-1:0] cand;
  logic [NUM_LINES-1:0] m_part;
  logic [NUM_LINES-1:0] s_part;

  assign cand   = pend_i & en_i;
  assign m_ok_o = mach_lines_open(priv_i, mie_i);
  assign s_ok_o = super_lines_open(priv_i, sie_i);

  assign m_part  = cand & ~deleg_i & {NUM_LINES{m_ok_o}};
  assign s_part  = cand &  deleg_i & {NUM_LINES{s_ok_o}};
  assign final_o = m_part | s_part;

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int NUM_LINES = 16,
  parameter int GROUP     = 4,
  localparam int IW       = $clog2(NUM_LINES),
  localparam int GW       = $clog2(GROUP),
  localparam int NG       = (NUM_LINES + GROUP - 1) / GROUP,
  localparam int PADW     = NG * GROUP
) (
  input  logic [NUM_LINES-1:0] vec_i,
  output logic                 any_o,
  output logic [IW-1:0]        idx_o
);

  logic [PADW-1:0] padded;
  logic [NG-1:0]   grp_any;
  logic [GW-1:0]   grp_off [NG];

  function automatic logic [GW-1:0] first_in_group(input logic [GROUP-1:0] b);
    logic [GW-1:0] r;
    r = '0;
    for (int k = GROUP - 1; k >= 0; k--) begin
      if (b[k]) r = GW'(k);
    end
    return r;
  endfunction

  always_comb begin
    padded = '0;
    padded[NUM_LINES-1:0] = vec_i;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP +: GROUP];
    assign grp_off[g] = first_in_group(padded[g*GROUP +: GROUP]);
  end

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (grp_any[g]) begin
        any_o = 1'b1;
        idx_o = IW'(g * GROUP) + IW'(grp_off[g]);
      end
    end
  end

  logic [NUM_LINES-1:0] below_mask;
  assign below_mask = (NUM_LINES'(1) << idx_o) - NUM_LINES'(1);

  // R5: the reported bit is set and nothing below it is set
  always_comb begin
    if (any_o) begin
      assert_lowest_R5: assert (vec_i[idx_o] && ((vec_i & below_mask) == '0));
    end else begin
      assert_none_R6: assert (vec_i == '0);
    end
  end

endmodule

// File: rtl/irq_route_sel.sv
module irq_route_sel
  import irq_sel_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int GROUP     = 4,
  localparam int IW       = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic [NUM_LINES-1:0] deleg_i,
  input  logic [1:0]           priv_i,
  input  logic                 mie_i,
  input  logic                 sie_i,
  output logic                 irq_valid_o,
  output logic [IW-1:0]        irq_idx_o
);

  priv_e                priv;
  logic                 m_ok;
  logic                 s_ok;
  logic [NUM_LINES-1:0] final_set;
  logic                 sel_any;
  logic [IW-1:0]        sel_idx;

  assign priv = priv_e'(priv_i);

  irq_gate #(.NUM_LINES(NUM_LINES)) u_gate (
    .pend_i  (pend_i),
    .en_i    (en_i),
    .deleg_i (deleg_i),
    .priv_i  (priv),
    .mie_i   (mie_i),
    .sie_i   (sie_i),
    .m_ok_o  (m_ok),
    .s_ok_o  (s_ok),
    .final_o (final_set)
  );

  irq_first_set #(.NUM_LINES(NUM_LINES), .GROUP(GROUP)) u_pick (
    .vec_i (final_set),
    .any_o (sel_any),
    .idx_o (sel_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid_o <= 1'b0;
      irq_idx_o   <= '0;
    end else begin
      irq_valid_o <= sel_any;
      irq_idx_o   <= sel_any ? sel_idx : '0;
    end
  end

  assert_cand_subset_R2: assert property (@(posedge clk) disable iff (rst)
    (final_set & ~(pend_i & en_i)) == '0);

  assert_mach_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (!m_ok || (priv_i == 2'd3 && !mie_i)) |-> ((final_set & ~deleg_i) == '0));

  assert_super_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (!s_ok || priv_i[1] || (priv_i == 2'd1 && !sie_i)) |-> ((final_set & deleg_i) == '0));

  assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !sel_any |=> (!irq_valid_o && irq_idx_o == '0));

  assert_reg_follow_R7: assert property (@(posedge clk) disable iff (rst)
    sel_any |=> (irq_valid_o && irq_idx_o == $past(sel_idx)));

endmodule

// File: tb/tb_irq_route_sel.sv
module tb_irq_route_sel;

  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pend_i = '0;
  logic [N-1:0]  en_i = '0;
  logic [N-1:0]  deleg_i = '0;
  logic [1:0]    priv_i = 2'd0;
  logic          mie_i = 1'b0;
  logic          sie_i = 1'b0;
  logic          irq_valid_o;
  logic [IW-1:0] irq_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_route_sel #(.NUM_LINES(N)) dut (
    .clk(clk), .rst(rst), .pend_i(pend_i), .en_i(en_i), .deleg_i(deleg_i),
    .priv_i(priv_i), .mie_i(mie_i), .sie_i(sie_i),
    .irq_valid_o(irq_valid_o), .irq_idx_o(irq_idx_o)
  );

  task automatic expect_out(input logic v, input int idx, input string tag);
    checks++;
    if (irq_valid_o !== v || irq_idx_o !== IW'(idx)) begin
      errors++;
      $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
               tag, irq_valid_o, irq_idx_o, v, idx);
    end
  endtask

  // drive at falling edge, then sample just after the registering edge
  task automatic step(input logic [N-1:0] p, input logic [N-1:0] e,
                      input logic [N-1:0] d, input logic [1:0] pr,
                      input logic m, input logic s);
    @(negedge clk);
    pend_i = p; en_i = e; deleg_i = d; priv_i = pr; mie_i = m; sie_i = s;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    pend_i = '1; en_i = '1; deleg_i = '0; priv_i = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    expect_out(1'b0, 0, "R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    pend_i = '0; en_i = '0;
    @(posedge clk);
    #1;
    expect_out(1'b0, 0, "R1 after reset");
  endtask

  task automatic t_mask;
    step(16'h0010, 16'h0000, '0, 2'd0, 1'b1, 1'b1);
    expect_out(1'b0, 0, "R2 pending but disabled");
    step(16'h0010, 16'h0010, '0, 2'd0, 1'b1, 1'b1);
    expect_out(1'b1, 4, "R2 pending and enabled");
    step(16'h00F0, 16'h00C0, '0, 2'd0, 1'b1, 1'b1);
    expect_out(1'b1, 6, "R2 lowest enabled among pending");
  endtask

  task automatic t_mach;
    step(16'h0100, 16'h0100, '0, 2'd3, 1'b0, 1'b1);
    expect_out(1'b0, 0, "R3 machine level, mie clear");
    step(16'h0100, 16'h0100, '0, 2'd3, 1'b1, 1'b0);
    expect_out(1'b1, 8, "R3 machine level, mie set");
    step(16'h0100, 16'h0100, '0, 2'd1, 1'b0, 1'b0);
    expect_out(1'b1, 8, "R3 supervisor level ignores mie");
    step(16'h0100, 16'h0100, '0, 2'd0, 1'b0, 1'b0);
    expect_out(1'b1, 8, "R3 user level ignores mie");
  endtask

  task automatic t_super;
    step(16'h0100, 16'h0100, 16'h0100, 2'd3, 1'b1, 1'b1);
    expect_out(1'b0, 0, "R4 blocked in machine level");
    step(16'h0100, 16'h0100, 16'h0100, 2'd1, 1'b1, 1'b0);
    expect_out(1'b0, 0, "R4 supervisor level, sie clear");
    step(16'h0100, 16'h0100, 16'h0100, 2'd1, 1'b0, 1'b1);
    expect_out(1'b1, 8, "R4 supervisor level, sie set");
    step(16'h0100, 16'h0100, 16'h0100, 2'd0, 1'b0, 1'b0);
    expect_out(1'b1, 8, "R4 user level ignores sie");
    step(16'h0101, 16'h0101, 16'h0001, 2'd2, 1'b0, 1'b1);
    expect_out(1'b1, 8, "R4 encoding 2 blocks delegated, opens machine");
  endtask

  task automatic t_union;
    step(16'hFFFF, 16'hFFFF, 16'h00FF, 2'd1, 1'b0, 1'b0);
    expect_out(1'b1, 8, "R5 only machine half open");
    step(16'hFFFF, 16'hFFFF, 16'h00FF, 2'd1, 1'b0, 1'b1);
    expect_out(1'b1, 0, "R5 both halves open");
    step(16'hFFFF, 16'hFFFF, 16'h00FF, 2'd3, 1'b1, 1'b1);
    expect_out(1'b1, 8, "R5 machine level keeps delegated half shut");
    step(16'h8000, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0);
    expect_out(1'b1, 15, "R5 top line alone");
    step(16'h8000, 16'hFFFF, 16'h8000, 2'd0, 1'b0, 1'b0);
    expect_out(1'b1, 15, "R5 top line delegated from user");
  endtask

  task automatic t_empty;
    step(16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1);
    expect_out(1'b0, 0, "R6 nothing pending after a hit");
    step(16'h0F00, 16'h0F00, 16'h0F00, 2'd3, 1'b1, 1'b1);
    expect_out(1'b0, 0, "R6 all filtered out");
  endtask

  task automatic t_latency;
    step(16'h0004, 16'h0004, '0, 2'd0, 1'b0, 1'b0);
    expect_out(1'b1, 2, "R7 first value");
    @(negedge clk);
    pend_i = 16'h0020; en_i = 16'h0020;
    #2;
    expect_out(1'b1, 2, "R7 holds until edge");
    @(posedge clk);
    #1;
    expect_out(1'b1, 5, "R7 updates after edge");
  endtask

  task automatic t_indep;
    step(16'h0200, 16'h0200, 16'h0000, 2'd3, 1'b0, 1'b1);
    expect_out(1'b0, 0, "R8 sie does not open machine lines");
    step(16'h0200, 16'h0200, 16'h0200, 2'd1, 1'b0, 1'b1);
    expect_out(1'b1, 9, "R8 mie clear does not block delegated lines");
    step(16'h0200, 16'h0200, 16'h0200, 2'd1, 1'b1, 1'b0);
    expect_out(1'b0, 0, "R8 mie set does not open delegated lines");
  endtask

  initial begin
    t_reset();
    t_mask();
    t_mach();
    t_super();
    t_union();
    t_empty();
    t_latency();
    t_indep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule